// File: doc/BRIEF.md
# Thirty-Two Level Priority Interrupt Controller

This block sits next to a processor core and decides which of thirty-two prioritised interrupt levels the core should take next. Each level has a request strobe and an eight-bit description byte supplied by its device. A request is latched as pending and stays pending until it is accepted or cancelled. A 32-bit enable mask selects which pending levels may be taken. An in-service record lets a more urgent level interrupt a less urgent one.

When a level is accepted, the block raises a one-cycle interrupt pulse. With it come the level number, the byte addresses of that level's save slot and fetch slot for status words, and the captured description byte. The core stores the description byte in bits 24 to 31 of the saved status word. The core also presents the mask byte and instruction address of the fetched status word. The block returns a handler address whose index field is that mask byte XORed with the description, so each device can steer into its own entry of a jump table.

The core controls the block with mask commands and an exit strobe. Mask commands run in four modes: enable, disable, cancel, and cancel-and-enable. The exit strobe retires the routine that is currently running.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Levels are numbered 0 to 31 and 0 is the most urgent. When several levels are eligible in the same cycle, the lowest-numbered one is accepted.
- R2: A level is eligible only if it is pending, enabled, and numbered strictly below the level currently in service (any level qualifies when nothing is in service). An equal or less urgent request stays pending.
- R3: On acceptance of level k, the save slot address is 0x800 + 16·k and the fetch slot address is that value plus 8. Every slot therefore lies in 0x800 to 0x9FF.
- R4: A request strobe on level k latches its description byte, and the level's pending flag becomes visible one cycle later. If the level is eligible, irq_o pulses for one cycle in the following cycle, carrying k and that byte. Acceptance also clears the pending flag.
- R5: While irq_o is high, handler_addr_o equals nsw_ia_i with bits [9:2] replaced by nsw_mask_i XOR the description byte. nsw_mask_i carries bits 16 to 23 of the fetched status word.
- R6: Enable bit 31−k of mask_o (and of cmd_opnd_i) belongs to level k, and 1 means enabled. A request on a disabled level is not lost: bit 31−k of pending_o stays 1.
- R7: A command in mode 2'b10 ({mask bit, cancel bit}) sets the enable bits of levels whose operand bit is 1 and leaves the other enable bits unchanged.
- R8: A command in mode 2'b00 clears the enable bits of levels whose operand bit is 0 and keeps the others.
- R9: A command in mode 2'b01 drops the pending requests of levels whose operand bit is 1 and leaves mask_o unchanged.
- R10: A command in mode 2'b11 drops the pending requests of the tagged levels and enables them in the same cycle, so those dropped requests are never accepted.
- R11: exit_i retires the most urgent in-service level. cur_lvl_o then shows the next in-service level, or cur_valid_o falls when none remains, after which pending levels become eligible again.
- R12: After reset, mask_o and pending_o are zero, irq_o is low and cur_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 32 | Request strobe per level, bit k = level k |
| desc_i | input | 256 | Description bytes, level k in bits [8k+7:8k] |
| cmd_valid_i | input | 1 | Mask command strobe |
| cmd_mode_i | input | 2 | {mask bit, cancel bit} command mode |
| cmd_opnd_i | input | 32 | Command operand, bit 31−k tags level k |
| exit_i | input | 1 | Retire the current level |
| nsw_mask_i | input | 8 | Mask byte of the fetched status word |
| nsw_ia_i | input | 24 | Instruction address of the fetched status word |
| irq_o | output | 1 | One-cycle acceptance pulse |
| irq_lvl_o | output | 5 | Accepted level |
| old_sw_addr_o | output | 24 | Save slot byte address |
| new_sw_addr_o | output | 24 | Fetch slot byte address |
| irq_desc_o | output | 8 | Captured description byte |
| handler_addr_o | output | 24 | Handler address with jump-table index |
| cur_valid_o | output | 1 | A level is in service |
| cur_lvl_o | output | 5 | Most urgent in-service level |
| mask_o | output | 32 | Enable mask, bit 31−k = level k |
| pending_o | output | 32 | Pending flags, bit 31−k = level k |

## Verification
A corrupted in-service record shows up as a missing or spurious preemption. The bench sees it on cur_lvl_o at the next sampling point after an accept or exit, and sees it again when an exit fails to let a held-back level through. A mask or pending flag that holds the wrong value is visible on mask_o or pending_o within one cycle of the command or request. A wrong arbitration choice or a stale description byte shows in the first acceptance pulse that follows, because the order and contents of that pulse are compared against a queue of expected acceptances.

// File: rtl/lic_pkg.sv
// Package: shared constants and command encoding for the priority
// interrupt controller. Assumes one status word slot pair per level.
package lic_pkg;

    // Width of a device description byte and of the status-word mask byte.
    localparam int unsigned DESC_W = 8;

    // Width of a status word instruction address.
    localparam int unsigned IA_W = 24;

    // Command modes, encoded as {mask bit, cancel bit}.
    typedef enum logic [1:0] {
        CMD_DISABLE   = 2'b00,
        CMD_CANCEL    = 2'b01,
        CMD_ENABLE    = 2'b10,
        CMD_CANCEL_EN = 2'b11
    } cmd_mode_e;

endpackage

// File: rtl/lic_arbiter.sv
// Fixed-priority finder: reports whether any candidate is set, the lowest
// set index, and a one-hot grant. Purely combinational.
module lic_arbiter #(
    parameter  int unsigned N  = 32,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  cand_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  grant_o
);

    // Scan from least to most urgent so the lowest index is the last write.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (cand_i[k]) begin
                hit_o = 1'b1;
                idx_o = IW'(k);
            end
        end
    end

    // Expand the winning index into a one-hot grant vector.
    for (genvar g = 0; g < N; g++) begin : g_grant
        assign grant_o[g] = hit_o && (idx_o == IW'(g));
    end

endmodule

// File: rtl/lic_pend_bank.sv
// Pending-request bank: one pending flag and one description register per
// level. A new request wins over a cancel or take in the same cycle.
module lic_pend_bank #(
    parameter int unsigned N      = 32,
    parameter int unsigned DESC_W = lic_pkg::DESC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req_i,
    input  logic [N*DESC_W-1:0] desc_i,
    input  logic [N-1:0]      cancel_i,
    input  logic [N-1:0]      take_i,
    output logic [N-1:0]      pend_o,
    output logic [N*DESC_W-1:0] desc_o
);

    for (genvar g = 0; g < N; g++) begin : g_lvl
        // Pending flag: set by request, cleared by cancel or acceptance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_o[g] <= 1'b0;
            end else if (req_i[g]) begin
                pend_o[g] <= 1'b1;
            end else if (cancel_i[g] || take_i[g]) begin
                pend_o[g] <= 1'b0;
            end
        end

        // Description byte: latched with every request on this level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                desc_o[g*DESC_W +: DESC_W] <= '0;
            end else if (req_i[g]) begin
                desc_o[g*DESC_W +: DESC_W] <= desc_i[g*DESC_W +: DESC_W];
            end
        end
    end

endmodule

// File: rtl/lic_mask_reg.sv
// Enable mask and command decoder. Operand bit N-1-k tags level k. Produces
// a level-indexed enable vector and a level-indexed cancel strobe.
module lic_mask_reg #(
    parameter int unsigned N = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid_i,
    input  lic_pkg::cmd_mode_e  cmd_mode_i,
    input  logic [N-1:0]        cmd_opnd_i,
    output logic [N-1:0]        en_o,
    output logic [N-1:0]        mask_o,
    output logic [N-1:0]        cancel_o
);

    logic [N-1:0] tag;

    // Map operand order (level 0 at the top bit) onto level order.
    for (genvar g = 0; g < N; g++) begin : g_map
        assign tag[g]    = cmd_opnd_i[N-1-g];
        assign mask_o[g] = en_o[N-1-g];
    end

    // Enable register update per command mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o <= '0;
        end else if (cmd_valid_i) begin
            case (cmd_mode_i)
                lic_pkg::CMD_ENABLE:    en_o <= en_o | tag;
                lic_pkg::CMD_DISABLE:   en_o <= en_o & tag;
                lic_pkg::CMD_CANCEL_EN: en_o <= en_o | tag;
                default:                en_o <= en_o;
            endcase
        end
    end

    // Cancel strobe: active for both modes that carry the cancel bit.
    always_comb begin
        cancel_o = '0;
        if (cmd_valid_i && cmd_mode_i[0]) begin
            cancel_o = tag;
        end
    end

endmodule

// File: rtl/lic_service.sv
// In-service record: one bit per level. The most urgent set bit is the
// current level; exit clears it. Also gives the set of levels above it.
module lic_service #(
    parameter  int unsigned N  = 32,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  take_i,
    input  logic          exit_i,
    output logic          cur_valid_o,
    output logic [IW-1:0] cur_idx_o,
    output logic [N-1:0]  above_o
);

    logic [N-1:0] isv_q;
    logic [N-1:0] cur_oh;

    lic_arbiter #(.N(N)) u_cur (
        .cand_i  (isv_q),
        .hit_o   (cur_valid_o),
        .idx_o   (cur_idx_o),
        .grant_o (cur_oh)
    );

    // Retire the current level on exit, record newly accepted levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isv_q <= '0;
        end else begin
            isv_q <= (isv_q & ~({N{exit_i}} & cur_oh)) | take_i;
        end
    end

    // Levels strictly more urgent than the current one (all when idle).
    for (genvar g = 0; g < N; g++) begin : g_above
        assign above_o[g] = !cur_valid_o || (IW'(g) < cur_idx_o);
    end

endmodule

// File: rtl/lvl_irq_ctrl.sv
// Top of the priority interrupt controller. Combines pending, mask and
// in-service state, arbitrates combinationally, and registers a one-cycle
// acceptance with level, slot addresses and description. Assumes the core
// presents the fetched status word's mask byte and address while irq_o is high.
module lvl_irq_ctrl #(
    parameter  int unsigned LEVELS     = 32,
    parameter  int unsigned ADDR_W     = 24,
    parameter  int unsigned SLOT_BASE  = 'h800,
    parameter  int unsigned SLOT_BYTES = 16,
    parameter  int unsigned NEW_OFS    = 8,
    localparam int unsigned LVL_W      = $clog2(LEVELS),
    localparam int unsigned DESC_W     = lic_pkg::DESC_W,
    localparam int unsigned IA_W       = lic_pkg::IA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LEVELS-1:0]        req_i,
    input  logic [LEVELS*DESC_W-1:0] desc_i,
    input  logic                     cmd_valid_i,
    input  logic [1:0]               cmd_mode_i,
    input  logic [LEVELS-1:0]        cmd_opnd_i,
    input  logic                     exit_i,
    input  logic [DESC_W-1:0]        nsw_mask_i,
    input  logic [IA_W-1:0]          nsw_ia_i,
    output logic                     irq_o,
    output logic [LVL_W-1:0]         irq_lvl_o,
    output logic [ADDR_W-1:0]        old_sw_addr_o,
    output logic [ADDR_W-1:0]        new_sw_addr_o,
    output logic [DESC_W-1:0]        irq_desc_o,
    output logic [IA_W-1:0]          handler_addr_o,
    output logic                     cur_valid_o,
    output logic [LVL_W-1:0]         cur_lvl_o,
    output logic [LEVELS-1:0]        mask_o,
    output logic [LEVELS-1:0]        pending_o
);

    localparam int unsigned SLOT_SH = $clog2(SLOT_BYTES);
    localparam logic [IA_W-1:0] IDX_FIELD = IA_W'({DESC_W{1'b1}}) << 2;

    logic [LEVELS-1:0]        pend;
    logic [LEVELS-1:0]        en;
    logic [LEVELS-1:0]        cancel;
    logic [LEVELS-1:0]        above;
    logic [LEVELS-1:0]        elig;
    logic [LEVELS-1:0]        take;
    logic [LEVELS*DESC_W-1:0] desc_all;
    logic                     win_hit;
    logic [LVL_W-1:0]         win_idx;
    logic                     irq_q;
    logic [LVL_W-1:0]         lvl_q;
    logic [DESC_W-1:0]        desc_q;

    lic_pend_bank #(.N(LEVELS), .DESC_W(DESC_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .desc_i   (desc_i),
        .cancel_i (cancel),
        .take_i   (take),
        .pend_o   (pend),
        .desc_o   (desc_all)
    );

    lic_mask_reg #(.N(LEVELS)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid_i),
        .cmd_mode_i  (lic_pkg::cmd_mode_e'(cmd_mode_i)),
        .cmd_opnd_i  (cmd_opnd_i),
        .en_o        (en),
        .mask_o      (mask_o),
        .cancel_o    (cancel)
    );

    lic_service #(.N(LEVELS)) u_svc (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .exit_i      (exit_i),
        .cur_valid_o (cur_valid_o),
        .cur_idx_o   (cur_lvl_o),
        .above_o     (above)
    );

    // Eligible set: pending, enabled and more urgent than the current level.
    assign elig = pend & en & above;

    lic_arbiter #(.N(LEVELS)) u_arb (
        .cand_i  (elig),
        .hit_o   (win_hit),
        .idx_o   (win_idx),
        .grant_o (take)
    );

    // Register the acceptance pulse together with its level and description.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            lvl_q  <= '0;
            desc_q <= '0;
        end else begin
            irq_q <= win_hit;
            if (win_hit) begin
                lvl_q  <= win_idx;
                desc_q <= desc_all[win_idx*DESC_W +: DESC_W];
            end
        end
    end

    // Present pending flags in operand order (level 0 at the top bit).
    for (genvar g = 0; g < LEVELS; g++) begin : g_pend_out
        assign pending_o[g] = pend[LEVELS-1-g];
    end

    assign irq_o         = irq_q;
    assign irq_lvl_o     = lvl_q;
    assign irq_desc_o    = desc_q;
    assign old_sw_addr_o = ADDR_W'(SLOT_BASE) + (ADDR_W'(lvl_q) << SLOT_SH);
    assign new_sw_addr_o = old_sw_addr_o + ADDR_W'(NEW_OFS);

    // Handler address: index field replaced by mask byte XOR description.
    assign handler_addr_o = (nsw_ia_i & ~IDX_FIELD)
                          | (IA_W'(nsw_mask_i ^ desc_q) << 2);

endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
// Checker bound to lvl_irq_ctrl: relates acceptance, in-service state,
// slot addresses and mask commands over time at the ports.
module lvl_irq_ctrl_chk #(
    parameter int unsigned LEVELS     = 32,
    parameter int unsigned LVL_W      = 5,
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned SLOT_BASE  = 'h800,
    parameter int unsigned SLOT_BYTES = 16,
    parameter int unsigned NEW_OFS    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid_i,
    input logic [1:0]        cmd_mode_i,
    input logic [LEVELS-1:0] cmd_opnd_i,
    input logic              irq_o,
    input logic [LVL_W-1:0]  irq_lvl_o,
    input logic [ADDR_W-1:0] old_sw_addr_o,
    input logic [ADDR_W-1:0] new_sw_addr_o,
    input logic              cur_valid_o,
    input logic [LVL_W-1:0]  cur_lvl_o,
    input logic [LEVELS-1:0] mask_o
);

    localparam int unsigned LAST_SLOT = SLOT_BASE + (LEVELS - 1) * SLOT_BYTES;

    logic [LEVELS-1:0] mask_prev;

    // Mask as it stood in the cycle the acceptance was decided.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_prev <= '0;
        else        mask_prev <= mask_o;
    end

    // R2
    preempt_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(cur_valid_o)) |-> (irq_lvl_o < $past(cur_lvl_o)));

    // R11
    cur_tracks_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cur_valid_o && cur_lvl_o == irq_lvl_o));

    // R3
    slot_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (new_sw_addr_o == old_sw_addr_o + ADDR_W'(NEW_OFS)
                   && old_sw_addr_o >= ADDR_W'(SLOT_BASE)
                   && old_sw_addr_o <= ADDR_W'(LAST_SLOT)));

    // R6
    masked_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> mask_prev[LEVELS-1-int'(irq_lvl_o)]);

    // R9
    cancel_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_mode_i == 2'b01) |=> $stable(mask_o));

    // R7
    enable_sets_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_mode_i == 2'b10) |=>
            ((mask_o & $past(cmd_opnd_i)) == $past(cmd_opnd_i)));

endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(
    .LEVELS     (LEVELS),
    .LVL_W      (LVL_W),
    .ADDR_W     (ADDR_W),
    .SLOT_BASE  (SLOT_BASE),
    .SLOT_BYTES (SLOT_BYTES),
    .NEW_OFS    (NEW_OFS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_mode_i    (cmd_mode_i),
    .cmd_opnd_i    (cmd_opnd_i),
    .irq_o         (irq_o),
    .irq_lvl_o     (irq_lvl_o),
    .old_sw_addr_o (old_sw_addr_o),
    .new_sw_addr_o (new_sw_addr_o),
    .cur_valid_o   (cur_valid_o),
    .cur_lvl_o     (cur_lvl_o),
    .mask_o        (mask_o)
);

// File: tb/lvl_irq_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected acceptances, a monitor
// compares each irq_o pulse against the queue head.
module lvl_irq_ctrl_tb;

    typedef struct packed {
        logic [4:0] lvl;
        logic [7:0] desc;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  req_i = '0;
    logic [255:0] desc_i = '0;
    logic         cmd_valid_i = 1'b0;
    logic [1:0]   cmd_mode_i = 2'b00;
    logic [31:0]  cmd_opnd_i = '0;
    logic         exit_i = 1'b0;
    logic [7:0]   nsw_mask_i = 8'hA5;
    logic [23:0]  nsw_ia_i = 24'h123456;
    logic         irq_o;
    logic [4:0]   irq_lvl_o;
    logic [23:0]  old_sw_addr_o;
    logic [23:0]  new_sw_addr_o;
    logic [7:0]   irq_desc_o;
    logic [23:0]  handler_addr_o;
    logic         cur_valid_o;
    logic [4:0]   cur_lvl_o;
    logic [31:0]  mask_o;
    logic [31:0]  pending_o;

    int   n_chk  = 0;
    int   n_fail = 0;
    exp_t exp_q[$];

    lvl_irq_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (req_i),
        .desc_i         (desc_i),
        .cmd_valid_i    (cmd_valid_i),
        .cmd_mode_i     (cmd_mode_i),
        .cmd_opnd_i     (cmd_opnd_i),
        .exit_i         (exit_i),
        .nsw_mask_i     (nsw_mask_i),
        .nsw_ia_i       (nsw_ia_i),
        .irq_o          (irq_o),
        .irq_lvl_o      (irq_lvl_o),
        .old_sw_addr_o  (old_sw_addr_o),
        .new_sw_addr_o  (new_sw_addr_o),
        .irq_desc_o     (irq_desc_o),
        .handler_addr_o (handler_addr_o),
        .cur_valid_o    (cur_valid_o),
        .cur_lvl_o      (cur_lvl_o),
        .mask_o         (mask_o),
        .pending_o      (pending_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_take(input int lvl, input logic [7:0] d);
        exp_t e;
        e.lvl  = 5'(lvl);
        e.desc = d;
        exp_q.push_back(e);
    endtask

    task automatic raise(input int lvl, input logic [7:0] d);
        @(negedge clk);
        req_i[lvl] = 1'b1;
        desc_i[lvl*8 +: 8] = d;
        @(negedge clk);
        req_i = '0;
    endtask

    task automatic raise_two(input int la, input logic [7:0] da,
                             input int lb, input logic [7:0] db);
        @(negedge clk);
        req_i[la] = 1'b1;
        req_i[lb] = 1'b1;
        desc_i[la*8 +: 8] = da;
        desc_i[lb*8 +: 8] = db;
        @(negedge clk);
        req_i = '0;
    endtask

    task automatic cmd(input logic [1:0] mode, input logic [31:0] opnd);
        @(negedge clk);
        cmd_valid_i = 1'b1;
        cmd_mode_i  = mode;
        cmd_opnd_i  = opnd;
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic do_exit();
        @(negedge clk);
        exit_i = 1'b1;
        @(negedge clk);
        exit_i = 1'b0;
    endtask

    function automatic logic [31:0] bit_of(input int lvl);
        return 32'h1 << (31 - lvl);
    endfunction

    // Monitor: every acceptance must match the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && irq_o) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R2 unexpected accept: actual level %0d expected none", irq_lvl_o);
            end else begin
                exp_t e;
                logic [23:0] hexp;
                e = exp_q.pop_front();
                hexp = (nsw_ia_i & ~24'h0003FC) | (24'(nsw_mask_i ^ e.desc) << 2);
                chk("R1", "accepted level", 32'(irq_lvl_o), 32'(e.lvl));
                chk("R4", "description", 32'(irq_desc_o), 32'(e.desc));
                chk("R3", "save slot", 32'(old_sw_addr_o), 32'h800 + 32'(e.lvl) * 16);
                chk("R3", "fetch slot", 32'(new_sw_addr_o), 32'h808 + 32'(e.lvl) * 16);
                chk("R5", "handler address", 32'(handler_addr_o), 32'(hexp));
            end
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R12: reset state
        chk("R12", "irq after reset", 32'(irq_o), 0);
        chk("R12", "mask after reset", mask_o, 0);
        chk("R12", "pending after reset", pending_o, 0);
        chk("R12", "cur_valid after reset", 32'(cur_valid_o), 0);

        // R6: request on a disabled level stays pending
        raise(5, 8'h11);
        tick(3);
        chk("R6", "masked level pending", pending_o, bit_of(5));
        chk("R6", "no service while masked", 32'(cur_valid_o), 0);

        // R7, R4: enabling the level lets it be accepted
        expect_take(5, 8'h11);
        cmd(2'b10, bit_of(5));
        chk("R7", "mask after enable", mask_o, bit_of(5));
        tick(3);
        chk("R4", "pending cleared by accept", pending_o, 0);
        chk("R11", "current level", 32'(cur_lvl_o), 5);

        // R2: less urgent and equal requests wait, a more urgent one preempts
        cmd(2'b10, 32'hFFFF_FFFF);
        chk("R7", "mask all enabled", mask_o, 32'hFFFF_FFFF);
        raise(9, 8'h22);
        raise(5, 8'h33);
        tick(3);
        chk("R2", "lower and equal held", pending_o, bit_of(9) | bit_of(5));
        chk("R2", "current unchanged", 32'(cur_lvl_o), 5);
        expect_take(2, 8'h44);
        raise(2, 8'h44);
        tick(3);
        chk("R2", "preempted to level 2", 32'(cur_lvl_o), 2);

        // R11: exits resume the interrupted level, then release held ones
        do_exit();
        tick(2);
        chk("R11", "resumed level 5", 32'(cur_lvl_o), 5);
        chk("R11", "held requests remain", pending_o, bit_of(9) | bit_of(5));
        expect_take(5, 8'h33);
        do_exit();
        tick(3);
        chk("R11", "level 5 retaken", 32'(cur_lvl_o), 5);
        expect_take(9, 8'h22);
        do_exit();
        tick(3);
        chk("R11", "level 9 taken", 32'(cur_lvl_o), 9);
        do_exit();
        tick(2);
        chk("R11", "idle after last exit", 32'(cur_valid_o), 0);

        // R1: two simultaneous requests, most urgent first
        expect_take(1, 8'h66);
        raise_two(7, 8'h55, 1, 8'h66);
        tick(3);
        chk("R1", "level 1 first", 32'(cur_lvl_o), 1);
        chk("R1", "level 7 waiting", pending_o, bit_of(7));
        expect_take(7, 8'h55);
        do_exit();
        tick(3);
        chk("R1", "level 7 next", 32'(cur_lvl_o), 7);
        do_exit();
        tick(2);

        // R8: disable clears only levels tagged by 0
        cmd(2'b00, ~bit_of(3));
        chk("R8", "mask after disable", mask_o, ~bit_of(3));
        raise(3, 8'h77);
        tick(3);
        chk("R8", "disabled level pending", pending_o, bit_of(3));
        chk("R8", "disabled level not served", 32'(cur_valid_o), 0);

        // R9: cancel drops the request and leaves the mask
        cmd(2'b01, bit_of(3));
        chk("R9", "pending after cancel", pending_o, 0);
        chk("R9", "mask after cancel", mask_o, ~bit_of(3));
        cmd(2'b10, bit_of(3));
        tick(3);
        chk("R9", "cancelled request not served", 32'(cur_valid_o), 0);

        // R10: cancel-and-enable drops the request it enables
        cmd(2'b00, ~bit_of(4));
        raise(4, 8'h88);
        tick(2);
        chk("R10", "request held before command", pending_o, bit_of(4));
        cmd(2'b11, bit_of(4));
        tick(3);
        chk("R10", "pending after cancel-enable", pending_o, 0);
        chk("R10", "mask after cancel-enable", mask_o, 32'hFFFF_FFFF);
        chk("R10", "no service after cancel-enable", 32'(cur_valid_o), 0);

        // R5: other status-word mask byte and address
        nsw_mask_i = 8'h0F;
        nsw_ia_i   = 24'hABCDEF;
        expect_take(12, 8'hF0);
        raise(12, 8'hF0);
        tick(3);
        chk("R5", "level 12 in service", 32'(cur_lvl_o), 12);
        do_exit();
        tick(3);

        chk("R4", "all expected accepts seen", 32'(exp_q.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule